// File: doc/BRIEF.md
# Bus I/O Port Decoder

This block turns processor I/O cycles seen on a status-qualified bus into the enables that a small board of peripherals needs: a board-select, a read enable that doubles as the peripheral read strobe, a write enable, and eight one-hot chip selects. Each chip select owns a group of four consecutive ports. The two lowest address bits go straight through to the selected peripheral as its register select.

The board's base address is set by static switch inputs. An address bit is compared against a switch only when the current configuration says that bit belongs to the base. A switch that is ON (input at 1) requires that address bit to be 0. A switch that is OFF (input at 0) requires it to be 1. Two configuration inputs pick the board's port window and the I/O address width. The window is either 32 ports, with address bit 4 used in the select decode, or 16 ports, with bit 4 compared against a switch. The address width is either 8 bits (256 ports, with bits 15:8 ignored) or 16 bits (64K ports, with bits 15:5 all compared).

Chip selects 0 to 3 drive four counter selects, 4 and 5 drive two serial selects, and 6 drives the parallel select. Select 7 is decoded but reaches no peripheral. A separate output answers a sixteen-bit transfer request while the board is selected, but only when its enable input is set. Every output is a combinational function of the inputs.

Top module: `io_port_decoder`

## Requirements
- R1: `reg_sel_o` always equals address bits 1:0, whether or not the board is selected.
- R2: With `wide_window_i`=1 (32-port window) and the board selected, `cs_o` is one-hot at index address[4:2]. With the board not selected, `cs_o` is all zero.
- R3: With `wide_window_i`=0 (16-port window), address bit 4 must equal the inverse of `sw_win_i` for the board to be selected. The select index is {0, address[3:2]}, so `cs_o[7:4]` stay zero.
- R4: With `wide_addr_i`=0 (8-bit I/O), address bits 7:5 must each equal the inverse of `sw_mid_i[2:0]` (bit 5 against `sw_mid_i[0]`). Bits 15:8 have no effect on the board select.
- R5: With `wide_addr_i`=1 (16-bit I/O), address bits 9:5 are compared against the inverse of `sw_mid_i[4:0]` and bits 15:10 against the inverse of `sw_high_i[5:0]` (bit 10 against `sw_high_i[0]`). Any single mismatch deselects the board.
- R6: `wr_en_o` is 1 exactly when `wr_strobe_i`, `out_cycle_i` and `board_sel_o` are all 1.
- R7: `rd_en_o` is 1 exactly when `din_strobe_i`, `in_cycle_i` and `board_sel_o` are all 1 and the select index is not 7.
- R8: `ctr_sel_o[3:0]` follow `cs_o[3:0]`, `ser_sel_o[1:0]` follow `cs_o[5:4]` and `par_sel_o` follows `cs_o[6]`. An access at index 7 raises none of them.
- R9: `ack16_o` is 1 exactly when `req16_i`, `ack16_en_i` and `board_sel_o` are all 1. With `ack16_en_i`=0 it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 16 | I/O address from the bus |
| wr_strobe_i | input | 1 | Write strobe, active high |
| out_cycle_i | input | 1 | Status: output cycle in progress |
| din_strobe_i | input | 1 | Data-in strobe, active high |
| in_cycle_i | input | 1 | Status: input cycle in progress |
| wide_window_i | input | 1 | 1 = 32-port window, 0 = 16-port window |
| wide_addr_i | input | 1 | 1 = 16-bit I/O addressing, 0 = 8-bit |
| sw_win_i | input | 1 | Switch for address bit 4 (used only in the 16-port window), 1 = ON |
| sw_mid_i | input | 5 | Switches for address bits 9:5, 1 = ON |
| sw_high_i | input | 6 | Switches for address bits 15:10, 1 = ON |
| req16_i | input | 1 | Sixteen-bit transfer request |
| ack16_en_i | input | 1 | Enables the sixteen-bit acknowledge |
| board_sel_o | output | 1 | Address falls in the board's window |
| rd_en_o | output | 1 | Qualified read enable and peripheral read strobe |
| wr_en_o | output | 1 | Qualified write enable |
| cs_o | output | 8 | One-hot chip selects, four ports each |
| reg_sel_o | output | 2 | Register select passed to the peripherals |
| ctr_sel_o | output | 4 | Counter group selects |
| ser_sel_o | output | 2 | Serial controller selects |
| par_sel_o | output | 1 | Parallel controller select |
| ack16_o | output | 1 | Sixteen-bit acknowledge |

## Verification
The assertions assume that the switch and configuration inputs are static while an access is decoded, and that the inputs settle together, so combinational outputs are judged only after they have settled. The bench holds this by driving every input in one step on the rising clock edge and sampling on the falling edge. Random addresses are mostly built from the current switch settings, which keeps a large share of accesses inside the window. Single-bit flips then probe each compared field, and the bits that are not compared are randomised to show that they are ignored.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;

  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned REG_W    = 2;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned NUM_CS   = 1 << SEL_W;
  localparam int unsigned WIN_BIT  = REG_W + SEL_W - 1;
  localparam int unsigned LOW_BASE = WIN_BIT + 1;
  localparam int unsigned BYTE_TOP = 7;
  localparam int unsigned MID_TOP  = 9;
  localparam int unsigned BYTE_W   = BYTE_TOP - LOW_BASE + 1;
  localparam int unsigned MID_W    = MID_TOP - LOW_BASE + 1;
  localparam int unsigned HIGH_W   = ADDR_W - MID_TOP - 1;

  localparam int unsigned CTR_N    = 4;
  localparam int unsigned SER_N    = 2;
  localparam int unsigned PAR_N    = 1;
  localparam int unsigned SPARE_IX = CTR_N + SER_N + PAR_N;

  // A switch that is ON asks for a 0 on its address bit.
  // Bits where care is 0 always match.
  function automatic logic field_match(input logic [ADDR_W-1:0] addr,
                                       input logic [ADDR_W-1:0] sw_on,
                                       input logic [ADDR_W-1:0] care);
    return &((addr ^ sw_on) | ~care);
  endfunction

  // In the narrow window the top select bit is not part of the index.
  function automatic logic [SEL_W-1:0] sel_index(input logic [SEL_W-1:0] field,
                                                 input logic wide_window);
    return wide_window ? field : {1'b0, field[SEL_W-2:0]};
  endfunction

endpackage

// File: rtl/io_dec_match.sv
module io_dec_match
  import io_dec_pkg::*;
(
  input  logic [ADDR_W-1:WIN_BIT] addr_hi_i,
  input  logic                    wide_window_i,
  input  logic                    wide_addr_i,
  input  logic                    sw_win_i,
  input  logic [MID_W-1:0]        sw_mid_i,
  input  logic [HIGH_W-1:0]       sw_high_i,
  output logic                    board_sel_o
);

  logic [ADDR_W-1:0] addr_full;
  logic [ADDR_W-1:0] sw_full;
  logic [ADDR_W-1:0] care_full;

  assign addr_full = {addr_hi_i, {WIN_BIT{1'b0}}};

  always_comb begin
    sw_full                      = '0;
    sw_full[WIN_BIT]             = sw_win_i;
    sw_full[MID_TOP:LOW_BASE]    = sw_mid_i;
    sw_full[ADDR_W-1:MID_TOP+1]  = sw_high_i;
  end

  always_comb begin
    care_full = '0;
    for (int b = WIN_BIT; b < ADDR_W; b++) begin
      if (b == WIN_BIT)        care_full[b] = ~wide_window_i;
      else if (b <= BYTE_TOP)  care_full[b] = 1'b1;
      else                     care_full[b] = wide_addr_i;
    end
  end

  assign board_sel_o = field_match(addr_full, sw_full, care_full);

endmodule

// File: rtl/io_dec_select.sv
module io_dec_select
  import io_dec_pkg::*;
(
  input  logic [SEL_W-1:0]  field_i,
  input  logic              wide_window_i,
  input  logic              board_sel_i,
  output logic [NUM_CS-1:0] cs_o
);

  logic [SEL_W-1:0] idx;

  assign idx = sel_index(field_i, wide_window_i);

  for (genvar n = 0; n < NUM_CS; n++) begin : g_cs
    assign cs_o[n] = board_sel_i && (idx == SEL_W'(n));
  end

endmodule

// File: rtl/io_dec_strobes.sv
module io_dec_strobes (
  input  logic wr_strobe_i,
  input  logic out_cycle_i,
  input  logic din_strobe_i,
  input  logic in_cycle_i,
  input  logic board_sel_i,
  input  logic spare_hit_i,
  input  logic req16_i,
  input  logic ack16_en_i,
  output logic wr_en_o,
  output logic rd_en_o,
  output logic ack16_o
);

  logic write_cycle;
  logic read_cycle;

  assign write_cycle = wr_strobe_i & out_cycle_i;
  assign read_cycle  = din_strobe_i & in_cycle_i;

  assign wr_en_o = write_cycle & board_sel_i;
  assign rd_en_o = read_cycle & board_sel_i & ~spare_hit_i;
  assign ack16_o = req16_i & ack16_en_i & board_sel_i;

endmodule

// File: rtl/io_port_decoder.sv
module io_port_decoder
  import io_dec_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_strobe_i,
  input  logic              out_cycle_i,
  input  logic              din_strobe_i,
  input  logic              in_cycle_i,
  input  logic              wide_window_i,
  input  logic              wide_addr_i,
  input  logic              sw_win_i,
  input  logic [MID_W-1:0]  sw_mid_i,
  input  logic [HIGH_W-1:0] sw_high_i,
  input  logic              req16_i,
  input  logic              ack16_en_i,
  output logic              board_sel_o,
  output logic              rd_en_o,
  output logic              wr_en_o,
  output logic [NUM_CS-1:0] cs_o,
  output logic [REG_W-1:0]  reg_sel_o,
  output logic [CTR_N-1:0]  ctr_sel_o,
  output logic [SER_N-1:0]  ser_sel_o,
  output logic [PAR_N-1:0]  par_sel_o,
  output logic              ack16_o
);

  logic board_sel;
  logic spare_hit;

  io_dec_match i_match (
    .addr_hi_i     (addr_i[ADDR_W-1:WIN_BIT]),
    .wide_window_i (wide_window_i),
    .wide_addr_i   (wide_addr_i),
    .sw_win_i      (sw_win_i),
    .sw_mid_i      (sw_mid_i),
    .sw_high_i     (sw_high_i),
    .board_sel_o   (board_sel)
  );

  io_dec_select i_select (
    .field_i       (addr_i[WIN_BIT:REG_W]),
    .wide_window_i (wide_window_i),
    .board_sel_i   (board_sel),
    .cs_o          (cs_o)
  );

  assign spare_hit = cs_o[SPARE_IX];

  io_dec_strobes i_strobes (
    .wr_strobe_i  (wr_strobe_i),
    .out_cycle_i  (out_cycle_i),
    .din_strobe_i (din_strobe_i),
    .in_cycle_i   (in_cycle_i),
    .board_sel_i  (board_sel),
    .spare_hit_i  (spare_hit),
    .req16_i      (req16_i),
    .ack16_en_i   (ack16_en_i),
    .wr_en_o      (wr_en_o),
    .rd_en_o      (rd_en_o),
    .ack16_o      (ack16_o)
  );

  assign board_sel_o = board_sel;
  assign reg_sel_o   = addr_i[REG_W-1:0];
  assign ctr_sel_o   = cs_o[CTR_N-1:0];
  assign ser_sel_o   = cs_o[CTR_N+SER_N-1:CTR_N];
  assign par_sel_o   = cs_o[SPARE_IX-1:CTR_N+SER_N];

endmodule

// File: rtl/io_port_decoder_chk.sv
module io_port_decoder_chk
  import io_dec_pkg::*;
(
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_strobe_i,
  input logic              out_cycle_i,
  input logic              din_strobe_i,
  input logic              in_cycle_i,
  input logic              wide_window_i,
  input logic              wide_addr_i,
  input logic              sw_win_i,
  input logic [MID_W-1:0]  sw_mid_i,
  input logic [HIGH_W-1:0] sw_high_i,
  input logic              req16_i,
  input logic              ack16_en_i,
  input logic              board_sel_o,
  input logic              rd_en_o,
  input logic              wr_en_o,
  input logic [NUM_CS-1:0] cs_o,
  input logic [REG_W-1:0]  reg_sel_o,
  input logic [CTR_N-1:0]  ctr_sel_o,
  input logic [SER_N-1:0]  ser_sel_o,
  input logic [PAR_N-1:0]  par_sel_o,
  input logic              ack16_o
);

  always_comb begin
    AST_CS_ONEHOT: assert ($onehot0(cs_o)) else $error("cs not one-hot"); // R2
    if (|cs_o)
      AST_CS_NEEDS_BOARD: assert (board_sel_o) else $error("cs without board"); // R2
    if (!wide_window_i)
      AST_NARROW_WINDOW: assert (cs_o[NUM_CS-1:NUM_CS/2] == '0) else $error("upper cs in narrow window"); // R3
    if (!wide_window_i && board_sel_o)
      AST_WIN_BIT_MATCH: assert (addr_i[WIN_BIT] != sw_win_i) else $error("bit 4 mismatch"); // R3
    if (!wide_addr_i && board_sel_o)
      AST_BYTE_FIELD: assert ((addr_i[BYTE_TOP:LOW_BASE] ^ sw_mid_i[BYTE_W-1:0]) == '1) else $error("byte field"); // R4
    if (wide_addr_i && board_sel_o)
      AST_HIGH_FIELD: assert ((addr_i[ADDR_W-1:MID_TOP+1] ^ sw_high_i) == '1) else $error("high field"); // R5
    if (wr_en_o)
      AST_WR_QUAL: assert (wr_strobe_i && out_cycle_i && board_sel_o) else $error("write qual"); // R6
    if (rd_en_o)
      AST_RD_NOT_SPARE: assert (!cs_o[SPARE_IX] && din_strobe_i && in_cycle_i) else $error("read qual"); // R7
    if (cs_o[SPARE_IX])
      AST_SPARE_SILENT: assert (ctr_sel_o == '0 && ser_sel_o == '0 && par_sel_o == '0) else $error("spare reached device"); // R8
    if (ack16_o)
      AST_ACK_QUAL: assert (ack16_en_i && req16_i && board_sel_o) else $error("ack qual"); // R9
  end

endmodule

bind io_port_decoder io_port_decoder_chk i_chk (.*);

// File: tb/test_io_port_decoder.sv
module test_io_port_decoder;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [15:0] addr;
  logic wr_s, out_c, din_s, in_c, ww, wa, sw4, req16, ack_en;
  logic [4:0] swm;
  logic [5:0] swh;
  logic board, rd, wr, ack;
  logic [7:0] cs;
  logic [1:0] rs;
  logic [3:0] ctr;
  logic [1:0] ser;
  logic [0:0] par;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  io_port_decoder i_io_port_decoder (
    .addr_i(addr), .wr_strobe_i(wr_s), .out_cycle_i(out_c), .din_strobe_i(din_s),
    .in_cycle_i(in_c), .wide_window_i(ww), .wide_addr_i(wa), .sw_win_i(sw4),
    .sw_mid_i(swm), .sw_high_i(swh), .req16_i(req16), .ack16_en_i(ack_en),
    .board_sel_o(board), .rd_en_o(rd), .wr_en_o(wr), .cs_o(cs), .reg_sel_o(rs),
    .ctr_sel_o(ctr), .ser_sel_o(ser), .par_sel_o(par), .ack16_o(ack)
  );

  function automatic bit exp_board();
    bit ok = 1;
    if (!ww && addr[4] == sw4) ok = 0;
    for (int i = 0; i < 3; i++) if (addr[5+i] == swm[i]) ok = 0;
    if (wa) begin
      for (int i = 3; i < 5; i++) if (addr[5+i] == swm[i]) ok = 0;
      for (int i = 0; i < 6; i++) if (addr[10+i] == swh[i]) ok = 0;
    end
    return ok;
  endfunction

  function automatic logic [7:0] exp_cs();
    int idx = ww ? int'(addr[4:2]) : int'(addr[3:2]);
    return exp_board() ? (8'd1 << idx) : 8'd0;
  endfunction

  function automatic logic [15:0] matching_addr();
    logic [15:0] a = 16'($urandom);
    a[15:10] = ~swh;
    a[9:5]   = ~swm;
    if (!ww) a[4] = ~sw4;
    return a;
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] expv);
    checks++;
    if (got !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (addr %h ww %0b wa %0b)", tag, got, expv, addr, ww, wa);
    end
  endtask

  task automatic check_all();
    logic [7:0] ec = exp_cs();
    bit eb = exp_board();
    chk("R1 reg_sel", 8'(rs), 8'(addr[1:0]));
    chk(ww ? "R2 cs" : "R3 cs", cs, ec);
    chk(wa ? "R5 board" : "R4 board", 8'(board), 8'(eb));
    chk("R6 wr_en", 8'(wr), 8'(wr_s & out_c & eb));
    chk("R7 rd_en", 8'(rd), 8'(din_s & in_c & eb & ~ec[7]));
    chk("R8 routing", {1'b0, par, ser, ctr}, {1'b0, ec[6:0]});
    chk("R9 ack16", 8'(ack), 8'(req16 & ack_en & eb));
  endtask

  task automatic step();
    @(negedge clk);
    check_all();
    @(posedge clk);
  endtask

  task automatic idle();
    addr = '0; wr_s = 0; out_c = 0; din_s = 0; in_c = 0; ww = 1; wa = 0;
    sw4 = 0; swm = '0; swh = '0; req16 = 0; ack_en = 0;
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 idle wr", 8'(wr), 8'd0);
    chk("R7 idle rd", 8'(rd), 8'd0);
    chk("R9 idle ack", 8'(ack), 8'd0);
    @(posedge clk);

    // R7 R8: spare index read in 32-port window
    swm = 5'b10110; ww = 1; wa = 0;
    addr = matching_addr(); addr[4:2] = 3'd7; din_s = 1; in_c = 1;
    step();
    // R3: 16-port window, bit 4 wrong
    ww = 0; sw4 = 1; addr = matching_addr(); addr[4] = 1'b1;
    step();
    // R4: 8-bit mode, garbage in upper byte ignored
    ww = 1; wa = 0; addr = matching_addr(); addr[15:8] = 8'hA5; wr_s = 1; out_c = 1;
    step();
    // R5: 16-bit mode, each high bit flipped in turn
    wa = 1; swh = 6'b011001;
    for (int b = 5; b < 16; b++) begin
      addr = matching_addr(); addr[b] = ~addr[b];
      step();
    end
    // R9: request without enable, then with enable
    addr = matching_addr(); req16 = 1; ack_en = 0;
    step();
    ack_en = 1;
    step();

    for (int n = 0; n < 3000; n++) begin
      {wr_s, out_c, din_s, in_c, req16, ack_en} = 6'($urandom);
      ww = 1'($urandom); wa = 1'($urandom); sw4 = 1'($urandom);
      swm = 5'($urandom); swh = 6'($urandom);
      addr = matching_addr();
      case ($urandom % 4)
        0: addr = 16'($urandom);
        1: begin int b = 4 + int'($urandom % 12); addr[b] = ~addr[b]; end
        default: ;
      endcase
      step();
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule